// File: doc/BRIEF.md
# Dual-File Crossbar Register File

The block holds two independent register files, each 16 words of 4 bits, and joins them to two data ports, A and B, through a small crossbar. Each file has its own word address and its own active-low write enable. Per port, one select bit picks the file the port reaches and one direction bit says whether the port reads from that file or writes into it. Each bidirectional port appears as a separate data-in bus, data-out bus and output-enable flag, so a pad or a bus driver outside the block can build the real tri-state connection.

Reads are combinational: a port in output mode shows the word at the current address of its selected file. Writes take effect on the rising clock edge. When both ports write into the same file in one cycle, port B's data is the one stored. When they write into different files, both files are updated on the same edge, each at its own address. An active-low asynchronous reset clears every word of both files.

Top module: `dual_file_xbar`

## Requirements
- R1: While and after reset (rst_n low), every word of both files reads as zero.
- R2: With a_dir_in low, a_dout shows the word at file 0 address f0_addr when a_sel is 0, and the word at file 1 address f1_addr when a_sel is 1.
- R3: With b_dir_in low, b_dout shows the word at file 0 address f0_addr when b_sel is 0, and the word at file 1 address f1_addr when b_sel is 1.
- R4: A port's output enable (a_oe, b_oe) is 1 exactly when its direction bit is 0 (output mode); with the direction bit at 1 (input mode) the enable is 0 and the port's data-out is all zeros.
- R5: On a rising clock edge where file N's write enable is low and exactly one input-mode port selects file N, that port's data is stored at file N's current address; reads show it from the next cycle on.
- R6: A file whose write enable is high is not changed by the clock edge, whatever the ports do.
- R7: When both ports are in input mode, select the same file, and that file's write enable is low, only port B's data is stored.
- R8: When both ports are in input mode and select different files with both write enables low, both files are written on the same edge, each at its own address.
- R9: A file that no input-mode port selects keeps its contents even when its write enable is low.
- R10: When both ports are in output mode and select the same file, a_dout and b_dout are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears both files |
| f0_addr | input | 4 | Word address of file 0 |
| f1_addr | input | 4 | Word address of file 1 |
| f0_we_n | input | 1 | Active-low write enable of file 0 |
| f1_we_n | input | 1 | Active-low write enable of file 1 |
| a_sel | input | 1 | File reached by port A (0 = file 0, 1 = file 1) |
| b_sel | input | 1 | File reached by port B (0 = file 0, 1 = file 1) |
| a_dir_in | input | 1 | Port A direction (0 = output, 1 = input) |
| b_dir_in | input | 1 | Port B direction (0 = output, 1 = input) |
| a_din | input | 4 | Data written through port A |
| b_din | input | 4 | Data written through port B |
| a_dout | output | 4 | Data read through port A |
| b_dout | output | 4 | Data read through port B |
| a_oe | output | 1 | Port A output enable |
| b_oe | output | 1 | Port B output enable |

## Verification
Read data and output enables are combinational, so they are due in the same cycle as the address, select and direction inputs; the bench changes inputs on the falling edge and samples one nanosecond later, well before the next rising edge. A write lands on the following rising edge and is due on reads from the next cycle, so the bench's model updates its copy of both files only after that edge and every later read is compared with the updated copy. Random cycles mix all sixteen select and direction combinations with both write enables, and directed cycles place same-file writes, split-file writes, masked writes and unselected files where their outcome is read back in the next cycle.

// File: rtl/dual_file_xbar.sv
module dual_file_xbar #(
  parameter int WORDS = 16,
  parameter int WIDTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(WORDS)-1:0] f0_addr,
  input  logic [$clog2(WORDS)-1:0] f1_addr,
  input  logic                     f0_we_n,
  input  logic                     f1_we_n,
  input  logic                     a_sel,
  input  logic                     b_sel,
  input  logic                     a_dir_in,
  input  logic                     b_dir_in,
  input  logic [WIDTH-1:0]         a_din,
  input  logic [WIDTH-1:0]         b_din,
  output logic [WIDTH-1:0]         a_dout,
  output logic [WIDTH-1:0]         b_dout,
  output logic                     a_oe,
  output logic                     b_oe
);
  localparam int AW = $clog2(WORDS);
  localparam int FILES = 2;

  logic [WIDTH-1:0] mem [FILES][WORDS];
  logic [AW-1:0]    addr [FILES];
  logic [FILES-1:0] we_n, a_hit, b_hit;
  logic [WIDTH-1:0] a_word, b_word;

  assign addr[0] = f0_addr;
  assign addr[1] = f1_addr;
  assign we_n    = {f1_we_n, f0_we_n};

  assign a_word = mem[a_sel][addr[a_sel]];
  assign b_word = mem[b_sel][addr[b_sel]];
  assign a_oe   = ~a_dir_in;
  assign b_oe   = ~b_dir_in;
  assign a_dout = a_oe ? a_word : '0;
  assign b_dout = b_oe ? b_word : '0;

  for (genvar f = 0; f < FILES; f++) begin : g_file
    assign a_hit[f] = a_dir_in && (a_sel == 1'(f));
    assign b_hit[f] = b_dir_in && (b_sel == 1'(f));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) mem[f][w] <= '0;
      end else if (!we_n[f] && (a_hit[f] || b_hit[f])) begin
        mem[f][addr[f]] <= b_hit[f] ? b_din : a_din;
      end
    end

    p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n[f] && a_hit[f] && !b_hit[f]) |=> mem[f][$past(addr[f])] == $past(a_din));

    p_b_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n[f] && b_hit[f]) |=> mem[f][$past(addr[f])] == $past(b_din));

    p_masked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we_n[f] |=> mem[f][$past(addr[f])] == $past(mem[f][addr[f]]));

    p_unselected_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_hit[f] && !b_hit[f]) |=> mem[f][$past(addr[f])] == $past(mem[f][addr[f]]));
  end

  p_input_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_dir_in |-> (!a_oe && a_dout == '0)) and (b_dir_in |-> (!b_oe && b_dout == '0)));

  p_shared_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_dir_in && !b_dir_in && a_sel == b_sel) |-> a_dout == b_dout);
endmodule

// File: tb/dual_file_xbar_tb_top.sv
module dual_file_xbar_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] f0_addr = '0, f1_addr = '0, a_din = '0, b_din = '0;
  logic f0_we_n = 1'b1, f1_we_n = 1'b1, a_sel = 1'b0, b_sel = 1'b0;
  logic a_dir_in = 1'b0, b_dir_in = 1'b0;
  logic [3:0] a_dout, b_dout;
  logic a_oe, b_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [3:0] model [2][16];

  always #2 clk = ~clk;

  dual_file_xbar dut_i (
    .clk(clk), .rst_n(rst_n), .f0_addr(f0_addr), .f1_addr(f1_addr),
    .f0_we_n(f0_we_n), .f1_we_n(f1_we_n), .a_sel(a_sel), .b_sel(b_sel),
    .a_dir_in(a_dir_in), .b_dir_in(b_dir_in), .a_din(a_din), .b_din(b_din),
    .a_dout(a_dout), .b_dout(b_dout), .a_oe(a_oe), .b_oe(b_oe));

  function automatic logic [3:0] exp_out(input logic sel, input logic dir_in);
    return dir_in ? 4'h0 : model[sel][sel ? f1_addr : f0_addr];
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_in(input logic [3:0] ad0, input logic [3:0] ad1, input logic w0n,
                        input logic w1n, input logic as, input logic bs, input logic ai,
                        input logic bi, input logic [3:0] ad, input logic [3:0] bd);
    f0_addr = ad0; f1_addr = ad1; f0_we_n = w0n; f1_we_n = w1n;
    a_sel = as; b_sel = bs; a_dir_in = ai; b_dir_in = bi; a_din = ad; b_din = bd;
  endtask

  task automatic step(input string atag, input string btag);
    logic ah0, ah1, bh0, bh1;
    #1;
    chk(atag, a_dout, exp_out(a_sel, a_dir_in));
    chk(btag, b_dout, exp_out(b_sel, b_dir_in));
    chk("R4", {3'b0, a_oe}, {3'b0, ~a_dir_in});
    chk("R4", {3'b0, b_oe}, {3'b0, ~b_dir_in});
    if (!a_dir_in && !b_dir_in && a_sel == b_sel) chk("R10", a_dout, b_dout);
    @(posedge clk);
    ah0 = a_dir_in && !a_sel; ah1 = a_dir_in && a_sel;
    bh0 = b_dir_in && !b_sel; bh1 = b_dir_in && b_sel;
    if (!f0_we_n && (ah0 || bh0)) model[0][f0_addr] = bh0 ? b_din : a_din;
    if (!f1_we_n && (ah1 || bh1)) model[1][f1_addr] = bh1 ? b_din : a_din;
    @(negedge clk);
  endtask

  task automatic read_both(input logic [3:0] ad0, input logic [3:0] ad1, input string tag);
    set_in(ad0, ad1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0);
    step(tag, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int f = 0; f < 2; f++) for (int w = 0; w < 16; w++) model[f][w] = '0;
    repeat (3) @(negedge clk);
    // R1: contents read zero during reset
    set_in(4'd5, 4'd9, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0);
    #1; chk("R1", a_dout, 4'h0); chk("R1", b_dout, 4'h0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    for (int w = 0; w < 16; w++) read_both(4'(w), 4'(15 - w), "R1");

    // R5: single write through A into file 1, then through B into file 0
    set_in(4'd2, 4'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hA, 4'h0);
    step("R4", "R3");
    read_both(4'd2, 4'd3, "R5");
    set_in(4'd7, 4'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 4'h6);
    step("R2", "R4");
    read_both(4'd7, 4'd3, "R5");

    // R7: both write file 0 at once, B wins
    set_in(4'd4, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h3, 4'hC);
    step("R4", "R4");
    #1; chk("R7", model[0][4], 4'hC);
    read_both(4'd4, 4'd0, "R7");

    // R8: split writes on one edge
    set_in(4'd8, 4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h5, 4'h9);
    step("R4", "R4");
    read_both(4'd8, 4'd8, "R8");

    // R6: write enable high blocks the write
    set_in(4'd8, 4'd8, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 4'hF);
    step("R4", "R4");
    read_both(4'd8, 4'd8, "R6");

    // R9: file 1 enabled but not selected by any input port
    set_in(4'd8, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h1, 4'h0);
    step("R4", "R3");
    read_both(4'd8, 4'd8, "R9");

    // R10: both ports read the same file
    set_in(4'd4, 4'd8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
    step("R2", "R10");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      set_in(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom));
      step("R2", "R3");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule